// File: doc/BRIEF.md
# MSI capability register file

This block holds the configuration-space registers of a message-signalled interrupt capability for one PCI function. Three parameters are fixed at build time: the number of vectors the function can raise (a power of two from 1 to 32), whether the message address may be 64 bits wide, and whether each vector can be masked on its own. These options set how many bytes the capability occupies and where each register sits within it.

Configuration accesses arrive as dword-aligned reads and writes with four byte enables. A write changes only the bytes that it enables, that fall inside the capability window, and that hold bits which are allowed to change. Read data is combinational on the address. The block hands the enable bit, the granted vector count, the message address and data, and the mask bits to the interrupt delivery logic. It reads the pending bits back from that logic. It also tells the delivery logic when to rescan, and it holds the legacy wire interrupt off while messages are enabled.

Top module: `msi_cap_regs`

## Requirements
- R1: After a synchronous active-low reset, the enable bit, the granted count, both address words, the data word and the mask bits are all zero. The dword at the base offset then reads with only its read-only flags set.
- R2: The control half-word is bits [31:16] of the dword at the base offset. Its bit 16 is the enable and bits [22:20] are the granted count (log2). Bits [19:17] read log2 of the vector count, bit 23 reads 1 when 64-bit addressing is built in, and bit 24 reads 1 when per-vector masking is built in. Writes never change these read-only flags.
- R3: Within the control half-word, only the enable bit and the granted count can be written. Every other bit of that dword reads zero.
- R4: The low address word sits at base+4. Its bits [1:0] always read zero.
- R5: In 64-bit mode, the upper address word sits at base+8 and all 32 of its bits are writable. In 32-bit mode, there is no upper word and msg_addr[63:32] stays zero.
- R6: The 16-bit data word is at base+8 in 32-bit mode and at base+0xC in 64-bit mode. It occupies bits [15:0] of that dword.
- R7: With masking built in, the mask dword is at base+0xC (32-bit) or base+0x10 (64-bit). Only bits 0 to N-1 can be written, where N is the vector count, and all other bits stay zero. Without masking, vec_mask is zero.
- R8: With masking built in, the dword after the mask returns pend_in limited to bits 0 to N-1. Without masking, that offset lies outside the window and reads zero.
- R9: On any write that lands in the window, if the resulting enable bit is 1 and the resulting granted count is larger than the capable count, the granted count is stored as the capable count. This holds whether the enable is being set by that write or was already set.
- R10: The window is 0x0A bytes long with neither option, 0x0E with 64-bit only, 0x14 with masking only, and 0x18 with both. Bytes outside the window, including the unused upper bytes of a partly covered dword, are never written and read zero.
- R11: intx_off is high exactly while the enable bit is set.
- R12: rescan is high for one cycle, in the cycle after every write that touches at least one byte of the window, and low otherwise.
- R13: A write changes only the bytes whose byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Byte address of the access, dword aligned |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, zero outside the window |
| pend_in | input | 32 | Pending bits kept by the delivery logic |
| msi_en | output | 1 | Message interrupts enabled |
| mme_log2 | output | 3 | Granted vector count, log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| intx_off | output | 1 | Forces the legacy wire interrupt off |
| rescan | output | 1 | One-cycle request to rescan pending vectors |

## Verification
The enable bit and the count clamp act in the same cycle when a single write sets the enable and an oversized granted count together. The bench provokes this with one write of 0x0071_0000 to the base dword and then reads back a granted count equal to the capable count. A narrow instance, built with one vector, 32-bit addressing and no masking, shares the same bus. The bench uses it to check that the same write clamps to zero there. The shared bus also shows a write that is inside one window and outside the other: one instance must pulse rescan while the other stays quiet.

// File: rtl/msi_cap_pkg.sv
// Package: shared helpers for the MSI capability register file.
// Assumes 32-bit configuration dwords split into four byte lanes.
package msi_cap_pkg;

    // Merge new data into a dword, keeping bytes that are not enabled and bits that are not writable
    function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                               input logic [31:0] nv,
                                               input logic [3:0]  lanes,
                                               input logic [31:0] wmask);
        logic [31:0] lm;
        for (int i = 0; i < 4; i++) begin
            lm[i*8 +: 8] = {8{lanes[i]}};
        end
        lm = lm & wmask;
        return (cur & ~lm) | (nv & lm);
    endfunction

    // Return a mask with the n low bits set (n from 0 to 32)
    function automatic logic [31:0] low_ones(input int n);
        logic [32:0] t;
        t = (33'd1 << n) - 33'd1;
        return t[31:0];
    endfunction

    // Return the capability length in bytes for the chosen options
    function automatic int cap_len(input bit a64, input bit pvm);
        if (a64 && pvm) return 24;
        if (a64)        return 14;
        if (pvm)        return 20;
        return 10;
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
// Module: address decoder for the capability window.
// Works out which dword of the capability is addressed and which byte lanes
// fall inside the window. Assumes the capability base is dword aligned.
module msi_cap_decode #(
    parameter int ADDR_W = 8,
    parameter int CAP_BASE = 'h40,
    parameter int CAP_LEN = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic [2:0]        dw_idx,
    output logic              in_win,
    output logic [3:0]        hit_lanes
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CAP_BASE);

    logic [ADDR_W-1:0] rel;
    logic              in_rng;
    int                dw_off;

    // Find the offset from the base and check that it lies within the six-dword span
    always_comb begin
        rel    = addr - BASE;
        in_rng = (addr >= BASE) && (rel < ADDR_W'(24));
        dw_off = int'({rel[ADDR_W-1:2], 2'b00});
        in_win = in_rng && (dw_off < CAP_LEN);
        dw_idx = rel[4:2];
    end

    // Keep each byte lane that is enabled and inside the window
    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign hit_lanes[i] = in_rng && be[i] && ((dw_off + i) < CAP_LEN);
    end
endmodule

// File: rtl/msi_cap_ctrl.sv
// Module: message control register (enable bit and granted vector count).
// Applies the clamp on the granted count whenever a window write leaves the
// enable bit set. Assumes wr_en is already qualified by address and window.
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    output logic        msi_en,
    output logic [2:0]  mme
);
    localparam logic [2:0]  MMC = 3'($clog2(NUM_VEC));
    localparam logic [31:0] WMASK = 32'h0071_0000;

    logic [31:0] merged;
    logic        en_n;
    logic [2:0]  mme_n;
    logic        unused_bits;

    // Build the next control state and clamp an oversized count while enabled
    always_comb begin
        merged = lane_merge({9'b0, mme, 3'b0, msi_en, 16'b0}, wdata, lanes, WMASK);
        en_n   = merged[16];
        mme_n  = merged[22:20];
        if (en_n && (mme_n > MMC)) mme_n = MMC;
    end
    assign unused_bits = ^{merged[31:23], merged[19:17], merged[15:0]};

    // Hold the control fields, updating them on window writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_en <= 1'b0;
            mme    <= 3'd0;
        end else if (wr_en) begin
            msi_en <= en_n;
            mme    <= mme_n;
        end
    end

    // R9: once messages are turned on, the granted count never exceeds the capable count
    assert_clamp_on_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_en) |-> (mme <= MMC));
    // R10: control state holds when no window write occurs
    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(msi_en) && $stable(mme)));
endmodule

// File: rtl/msi_cap_msg.sv
// Module: message address, data and mask registers.
// Which registers exist, and at which dword, follows ADDR64 and PVMASK.
// Assumes wr_en is qualified by the window and lanes are window-limited.
module msi_cap_msg
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 4,
    parameter bit ADDR64 = 1'b1,
    parameter bit PVMASK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  dw_idx,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    output logic [31:0] addr_lo,
    output logic [31:0] addr_hi,
    output logic [15:0] data,
    output logic [31:0] mask
);
    localparam logic [2:0]  DW_ALO  = 3'd1;
    localparam logic [2:0]  DW_AHI  = 3'd2;
    localparam logic [2:0]  DW_DATA = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0]  DW_MASK = DW_DATA + 3'd1;
    localparam logic [31:0] VALID   = low_ones(NUM_VEC);

    logic [31:0] data_m;
    logic        unused_bits;

    assign data_m      = lane_merge({16'b0, data}, wdata, lanes, 32'h0000_FFFF);
    assign unused_bits = ^data_m[31:16];

    // Keep the low address word and the data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
            data    <= '0;
        end else if (wr_en) begin
            if (dw_idx == DW_ALO)  addr_lo <= lane_merge(addr_lo, wdata, lanes, 32'hFFFF_FFFC);
            if (dw_idx == DW_DATA) data    <= data_m[15:0];
        end
    end

    if (ADDR64) begin : g_hi
        // Keep the upper address word
        always_ff @(posedge clk) begin
            if (!rst_n)                          addr_hi <= '0;
            else if (wr_en && dw_idx == DW_AHI)  addr_hi <= lane_merge(addr_hi, wdata, lanes, 32'hFFFF_FFFF);
        end
    end else begin : g_no_hi
        assign addr_hi = '0;
    end

    if (PVMASK) begin : g_mask
        // Keep the per-vector mask, limited to the configured vectors
        always_ff @(posedge clk) begin
            if (!rst_n)                          mask <= '0;
            else if (wr_en && dw_idx == DW_MASK) mask <= lane_merge(mask, wdata, lanes, VALID);
        end
        // R7: mask bits above the vector count stay clear
        assert_mask_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mask & ~VALID) == 32'd0);
    end else begin : g_no_mask
        assign mask = '0;
    end

    // R4: the two low address bits never become set
    assert_addr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lo[1:0] == 2'b00);
    // R10: message registers hold when no window write occurs
    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(addr_lo) && $stable(addr_hi) && $stable(data)));
endmodule

// File: rtl/msi_cap_regs.sv
// Module: MSI capability register file (top).
// Decodes configuration accesses into the capability window, holds the control,
// address, data and mask registers, and exports them to the delivery logic.
// Assumes dword-aligned addresses and a dword-aligned CAP_BASE.
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CAP_BASE = 'h40,
    parameter int NUM_VEC = 4,
    parameter bit ADDR64 = 1'b1,
    parameter bit PVMASK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       pend_in,
    output logic              msi_en,
    output logic [2:0]        mme_log2,
    output logic [63:0]       msg_addr,
    output logic [15:0]       msg_data,
    output logic [31:0]       vec_mask,
    output logic              intx_off,
    output logic              rescan
);
    localparam int          CAP_LEN = cap_len(ADDR64, PVMASK);
    localparam logic [2:0]  MMC     = 3'($clog2(NUM_VEC));
    localparam logic [2:0]  DW_DATA = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0]  DW_MASK = DW_DATA + 3'd1;
    localparam logic [2:0]  DW_PEND = DW_DATA + 3'd2;
    localparam logic [31:0] VALID   = low_ones(NUM_VEC);

    logic [2:0]  dw_idx;
    logic        in_win;
    logic [3:0]  hit_lanes;
    logic        wr_hit;
    logic [31:0] addr_lo, addr_hi;
    logic [15:0] ctrl_word;

    msi_cap_decode #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .CAP_LEN(CAP_LEN)) u_dec (
        .addr(cfg_addr), .be(cfg_be), .dw_idx(dw_idx), .in_win(in_win), .hit_lanes(hit_lanes)
    );

    assign wr_hit = cfg_wr && (|hit_lanes);

    msi_cap_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit && (dw_idx == 3'd0)),
        .lanes(hit_lanes), .wdata(cfg_wdata), .msi_en(msi_en), .mme(mme_log2)
    );

    msi_cap_msg #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .PVMASK(PVMASK)) u_msg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .dw_idx(dw_idx), .lanes(hit_lanes),
        .wdata(cfg_wdata), .addr_lo(addr_lo), .addr_hi(addr_hi), .data(msg_data), .mask(vec_mask)
    );

    assign msg_addr  = {addr_hi, addr_lo};
    assign intx_off  = msi_en;
    assign ctrl_word = {7'b0, PVMASK, ADDR64, mme_log2, MMC, msi_en};

    // Pulse the rescan request after every write that lands in the window
    always_ff @(posedge clk) begin
        if (!rst_n) rescan <= 1'b0;
        else        rescan <= wr_hit;
    end

    // Select the read data for the addressed dword
    always_comb begin
        cfg_rdata = '0;
        if (in_win) begin
            if (dw_idx == 3'd0)                     cfg_rdata = {ctrl_word, 16'h0000};
            else if (dw_idx == 3'd1)                cfg_rdata = addr_lo;
            else if (ADDR64 && dw_idx == 3'd2)      cfg_rdata = addr_hi;
            else if (dw_idx == DW_DATA)             cfg_rdata = {16'h0000, msg_data};
            else if (PVMASK && dw_idx == DW_MASK)   cfg_rdata = vec_mask;
            else if (PVMASK && dw_idx == DW_PEND)   cfg_rdata = pend_in & VALID;
        end
    end

    // R12: a rescan pulse always follows a write strobe
    assert_rescan_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(cfg_wr));
    // R11: the legacy interrupt is held off whenever messages are enabled
    assert_intx_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_en) |-> intx_off);
endmodule

// File: tb/msi_cap_regs_test.sv
module msi_cap_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] pend_in = 32'h0;

    logic [31:0] w_rdata, n_rdata;
    logic        w_en, n_en, w_intx, n_intx, w_rescan, n_rescan;
    logic [2:0]  w_mme, n_mme;
    logic [63:0] w_addr, n_addr;
    logic [15:0] w_data, n_data;
    logic [31:0] w_mask, n_mask;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    // Wide build: 4 vectors, 64-bit address, masking
    msi_cap_regs #(.ADDR_W(8), .CAP_BASE('h40), .NUM_VEC(4), .ADDR64(1'b1), .PVMASK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(w_rdata), .pend_in(pend_in), .msi_en(w_en),
        .mme_log2(w_mme), .msg_addr(w_addr), .msg_data(w_data), .vec_mask(w_mask),
        .intx_off(w_intx), .rescan(w_rescan)
    );

    // Narrow build on the same bus: 1 vector, 32-bit address, no masking
    msi_cap_regs #(.ADDR_W(8), .CAP_BASE('h40), .NUM_VEC(1), .ADDR64(1'b0), .PVMASK(1'b0)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(n_rdata), .pend_in(pend_in), .msi_en(n_en),
        .mme_log2(n_mme), .msg_addr(n_addr), .msg_data(n_data), .vec_mask(n_mask),
        .intx_off(n_intx), .rescan(n_rescan)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] wv, output logic [31:0] nv);
        cfg_addr = a;
        #1;
        wv = w_rdata;
        nv = n_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] wv, nv;
        rd(8'h40, wv, nv);
        chk("R1", "wide ctrl dword", wv, 32'h0184_0000);
        chk("R2", "narrow ctrl dword", nv, 32'h0000_0000);
        rd(8'h44, wv, nv);
        chk("R1", "addr lo", wv, 32'h0);
        chk("R1", "enable", {w_en, w_intx, w_rescan}, 3'b000);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] wv, nv;
        wr(8'h40, 4'hF, 32'hFFFE_FFFF);
        rd(8'h40, wv, nv);
        chk("R3", "wide ctrl after write, disabled", wv, 32'h01F4_0000);
        chk("R2", "narrow ctrl after write", nv, 32'h0070_0000);
        chk("R3", "granted count unclamped while off", w_mme, 3'd7);
        chk("R11", "intx off while disabled", w_intx, 1'b0);
    endtask

    task automatic t_clamp();
        logic [31:0] wv, nv;
        wr(8'h40, 4'b0100, 32'h0071_0000);
        rd(8'h40, wv, nv);
        chk("R9", "wide enable and clamp in one write", wv, 32'h01A5_0000);
        chk("R9", "narrow clamp to zero", nv, 32'h0001_0000);
        chk("R11", "intx off while enabled", {w_intx, n_intx}, 2'b11);
        wr(8'h40, 4'b0100, 32'h0051_0000);
        chk("R9", "clamp while already enabled", w_mme, 3'd2);
        wr(8'h40, 4'b0100, 32'h0011_0000);
        rd(8'h40, wv, nv);
        chk("R9", "legal count kept", wv, 32'h0195_0000);
        chk("R9", "narrow still clamped", nv, 32'h0001_0000);
        wr(8'h40, 4'b1011, 32'h0000_0000);
        rd(8'h40, wv, nv);
        chk("R13", "disabled lanes leave ctrl alone", wv, 32'h0195_0000);
    endtask

    task automatic t_address();
        logic [31:0] wv, nv;
        wr(8'h44, 4'hF, 32'hDEAD_BEEF);
        rd(8'h44, wv, nv);
        chk("R4", "addr lo low bits zero", wv, 32'hDEAD_BEEC);
        chk("R4", "narrow addr lo", nv, 32'hDEAD_BEEC);
        wr(8'h44, 4'b0101, 32'h1122_3344);
        rd(8'h44, wv, nv);
        chk("R13", "addr lo partial lanes", wv, 32'hDE22_BE44);
        wr(8'h48, 4'hF, 32'hCAFE_F00D);
        chk("R5", "wide addr hi", w_addr, 64'hCAFE_F00D_DE22_BE44);
        chk("R5", "narrow has no upper word", n_addr, 64'h0000_0000_DE22_BE44);
        rd(8'h48, wv, nv);
        chk("R6", "narrow data at base+8", nv, 32'h0000_F00D);
        chk("R6", "wide data untouched by base+8", w_data, 16'h0000);
    endtask

    task automatic t_data_rescan();
        logic [31:0] wv, nv;
        wr(8'h4C, 4'hF, 32'h1234_5678);
        chk("R12", "rescan pulse wide, none narrow", {w_rescan, n_rescan}, 2'b10);
        @(negedge clk);
        chk("R12", "rescan lasts one cycle", w_rescan, 1'b0);
        rd(8'h4C, wv, nv);
        chk("R6", "wide data at base+0xC", wv, 32'h0000_5678);
        chk("R10", "narrow data unchanged by out-of-window write", n_data, 16'hF00D);
        chk("R10", "narrow reads zero beyond window", nv, 32'h0);
        wr(8'h48, 4'b1100, 32'hAAAA_0000);
        chk("R10", "narrow ignores bytes past its length", {n_data, 15'b0, n_rescan}, {16'hF00D, 16'h0000});
        chk("R13", "wide upper lanes of addr hi", w_addr[63:32], 32'hAAAA_F00D);
    endtask

    task automatic t_mask_pend();
        logic [31:0] wv, nv;
        wr(8'h50, 4'hF, 32'hFFFF_FFFF);
        rd(8'h50, wv, nv);
        chk("R7", "mask limited to vector count", wv, 32'h0000_000F);
        chk("R7", "narrow mask absent", n_mask, 32'h0);
        pend_in = 32'hFFFF_FFF5;
        rd(8'h54, wv, nv);
        chk("R8", "pending readback limited", wv, 32'h0000_0005);
        rd(8'h50, wv, nv);
        chk("R8", "narrow reads zero at mask offset", nv, 32'h0);
    endtask

    task automatic t_outside();
        logic [31:0] wv, nv;
        wr(8'h3C, 4'hF, 32'hFFFF_FFFF);
        chk("R12", "no rescan below window", w_rescan, 1'b0);
        wr(8'h58, 4'hF, 32'hFFFF_FFFF);
        chk("R12", "no rescan above window", w_rescan, 1'b0);
        rd(8'h40, wv, nv);
        chk("R10", "ctrl unchanged by outside writes", wv, 32'h0195_0000);
        chk("R10", "data unchanged by outside writes", w_data, 16'h5678);
    endtask

    task automatic t_disable_and_reset();
        logic [31:0] wv, nv;
        wr(8'h40, 4'hF, 32'h0000_0000);
        chk("R11", "disable releases intx", {w_en, w_intx, w_mme}, 5'b00000);
        wr(8'h40, 4'b0100, 32'h0001_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h40, wv, nv);
        chk("R1", "ctrl after reset", wv, 32'h0184_0000);
        chk("R1", "address after reset", w_addr, 64'h0);
        chk("R1", "data and mask after reset", {w_data, w_mask, w_en}, 49'h0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ctrl_fields();
        t_clamp();
        t_address();
        t_data_rescan();
        t_mask_pend();
        t_outside();
        t_disable_and_reset();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule